// File: doc/BRIEF.md
# I2C Target with Run-Time Address Reassignment

This block is the bus-side logic of an I2C target for a family of boards that share one design but must sit at different bus addresses. Coming out of reset it answers at a base address set by a small board-type input. If the attached nonvolatile register port reports a saved address as valid, it answers at that saved address instead. A controller that writes a reassignment command to the current address moves the target to a new 7-bit address. The move happens at the STOP that closes the transaction, and in the same cycle the block strobes the new value out so that it can be kept in storage.

A small bank of byte registers sits behind the address. A write carries a register-index byte and then data bytes. A read returns bytes from the current index. The index advances by one after every data byte. The target also accepts writes to the general-call address. SCL and SDA are taken in through two-stage synchronisers, and START and STOP are recognised as SDA edges while SCL is high. The block drives SDA low only through an open-drain enable, and it never drives SCL.

Top module: `i2c_readdr_target`

## Requirements
- R1: In the first cycle after reset, when nv_valid is 0, the target takes the address 0x20 + board_type. It ACKs an address byte (7-bit address in bits 7:1, bit 0 = 1 for read) only for that address, or for 0x00 with bit 0 = 0. It releases SDA for every other address.
- R2: When nv_valid is 1 during reset, the target answers at nv_addr, and the board-type base address gets no ACK.
- R3: A write is the address byte, an index byte and then data bytes, and each of them gets an ACK. The register selected is the index byte's low 3 bits, out of 8 registers that reset to 0x00. Each data byte goes to the current index, and the index then advances modulo 8.
- R4: A read returns the register at the current index, MSB first, and advances the index modulo 8. It goes on to the next byte while the controller ACKs. After a controller NACK the target no longer drives SDA until the next START.
- R5: An index byte of 0x7E sent to the target's own address selects the reassignment command. The operand byte that follows gets an ACK if its value is between 0x08 and 0x77. The target keeps answering at its old address until the STOP, including across a repeated START, and from then on answers only at the operand value. The register contents are not changed.
- R6: A reassignment operand outside 0x08 to 0x77 gets a NACK. The address stays as it was and no storage strobe is raised.
- R7: nv_wr goes high for exactly one clock cycle, at the STOP that applies an accepted reassignment, with nv_wdata holding the new address. It stays low at all other times.
- R8: Through the general-call address 0x00 with write, the index and data bytes get an ACK and write the registers as in R3. A 0x00 read gets a NACK. A reassignment command sent through the general call gets an ACK but changes no address and raises no strobe.
- R9: The target pulls SDA low only in ACK slots and read-data bits, never while the controller is sending bits, and it changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| board_type | input | BT_W | Selects the base address 0x20 + board_type |
| nv_valid | input | 1 | A stored address is present |
| nv_addr | input | 7 | Stored address, loaded at reset when valid |
| nv_wr | output | 1 | One-cycle strobe to persist a new address |
| nv_wdata | output | 7 | Address to persist, valid with nv_wr |

## Verification
A wrong active address shows up on the next address byte. A matching address gets no ACK, or a foreign address gets one. The error appears in the ACK slot of that byte, about nine SCL periods after the START. A wrong index pointer or register content shows up in the first read-data byte after it, or as a misplaced byte when the bank is read back in one pass that wraps around. A pending reassignment that is lost or applied early shows up either at the first address probe after the STOP, or in an ACK given to the new address during a repeated START, and it also shows as a missing or extra nv_wr pulse.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_WACK, ST_TX, ST_RACK
  } eng_state_t;

  localparam logic [6:0] GC_ADDR  = 7'h00;
  localparam logic [7:0] CMD_IDX  = 8'h7E;
  localparam logic [7:0] ASSIGN_LO = 8'h08;
  localparam logic [7:0] ASSIGN_HI = 8'h77;

  function automatic logic addr_assignable(input logic [7:0] v);
    return (v >= ASSIGN_LO) && (v <= ASSIGN_HI);
  endfunction
endpackage

// File: rtl/i2ct_bus_sync.sv
module i2ct_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_m, scl_s, scl_q;
  logic sda_m, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      scl_q <= 1'b1;
      sda_m <= 1'b1;
      sda_s <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_m <= scl_in;
      scl_s <= scl_m;
      scl_q <= scl_s;
      sda_m <= sda_in;
      sda_s <= sda_m;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_evt = scl_s & scl_q & sda_q & ~sda_s;
    stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2ct_addr_ctl.sv
module i2ct_addr_ctl #(
  parameter int          BT_W      = 2,
  parameter logic [6:0]  BASE_ADDR = 7'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BT_W-1:0] board_type,
  input  logic            nv_valid,
  input  logic [6:0]      nv_addr,
  input  logic            pend_set,
  input  logic [6:0]      pend_addr,
  input  logic            apply,
  output logic [6:0]      active_addr,
  output logic            addr_ready,
  output logic            nv_wr,
  output logic [6:0]      nv_wdata
);
  localparam int PAD_W = 7 - BT_W;

  logic [6:0] base_addr;
  logic [6:0] active_d, pend_q, pend_d, wdata_d;
  logic       ready_d, pend_v_q, pend_v_d, wr_d;

  always_comb begin
    base_addr = BASE_ADDR + {{PAD_W{1'b0}}, board_type};
    ready_d   = 1'b1;
    active_d  = active_addr;
    pend_d    = pend_q;
    pend_v_d  = pend_v_q;
    wr_d      = 1'b0;
    wdata_d   = nv_wdata;
    if (!addr_ready) begin
      active_d = nv_valid ? nv_addr : base_addr;
    end else if (apply) begin
      pend_v_d = 1'b0;
      if (pend_v_q) begin
        active_d = pend_q;
        wr_d     = 1'b1;
        wdata_d  = pend_q;
      end
    end else if (pend_set) begin
      pend_d   = pend_addr;
      pend_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_ready  <= 1'b0;
      active_addr <= 7'h00;
      pend_q      <= 7'h00;
      pend_v_q    <= 1'b0;
      nv_wr       <= 1'b0;
      nv_wdata    <= 7'h00;
    end else begin
      addr_ready  <= ready_d;
      active_addr <= active_d;
      pend_q      <= pend_d;
      pend_v_q    <= pend_v_d;
      nv_wr       <= wr_d;
      nv_wdata    <= wdata_d;
    end
  end
endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [IW-1:0] SEL = IW'(i);
    logic hit;
    always_comb hit = we && (waddr == SEL);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (hit) begin
        mem[i] <= wdata;
      end
    end
  end

  always_comb rdata = mem[raddr];
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
  import i2ct_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sda_s,
  input  logic [6:0]    active_addr,
  input  logic          addr_ready,
  input  logic [7:0]    rdata,
  output logic          sda_oe,
  output logic          reg_we,
  output logic [IW-1:0] reg_ptr,
  output logic [7:0]    reg_wdata,
  output logic          pend_set,
  output logic [6:0]    pend_addr
);
  eng_state_t    st_q, st_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [7:0]    sr_q, sr_d;
  logic          full_q, full_d, rw_q, rw_d, gc_q, gc_d;
  logic          idx_q, idx_d, cmd_q, cmd_d, mack_q, mack_d, oe_d;
  logic [IW-1:0] ptr_d;
  logic          hit, gc_hit, ack;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sr_d = sr_q; full_d = full_q;
    rw_d = rw_q; gc_d = gc_q; idx_d = idx_q; cmd_d = cmd_q;
    mack_d = mack_q; oe_d = sda_oe; ptr_d = reg_ptr;
    reg_we = 1'b0; pend_set = 1'b0;
    hit    = addr_ready && (sr_q[7:1] == active_addr);
    gc_hit = (sr_q[7:1] == GC_ADDR) && !sr_q[0];
    ack    = 1'b0;
    if (stop_evt) begin
      st_d = ST_IDLE; oe_d = 1'b0; full_d = 1'b0;
    end else if (start_evt) begin
      st_d = ST_ADDR; cnt_d = 3'd0; full_d = 1'b0; oe_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise && !full_q) begin
            sr_d  = {sr_q[6:0], sda_s};
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) full_d = 1'b1;
          end else if (scl_fall && full_q) begin
            full_d = 1'b0;
            cnt_d  = 3'd0;
            if (st_q == ST_ADDR) begin
              if (hit || gc_hit) begin
                st_d = ST_AACK; oe_d = 1'b1;
                rw_d = sr_q[0]; gc_d = gc_hit; idx_d = 1'b1;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              if (idx_q) begin
                idx_d = 1'b0;
                ack   = 1'b1;
                if (sr_q == CMD_IDX) begin
                  cmd_d = 1'b1;
                end else begin
                  cmd_d = 1'b0;
                  ptr_d = sr_q[IW-1:0];
                end
              end else if (cmd_q) begin
                if (gc_q) begin
                  ack = 1'b1;
                end else if (addr_assignable(sr_q)) begin
                  ack      = 1'b1;
                  pend_set = 1'b1;
                end
              end else begin
                reg_we = 1'b1;
                ptr_d  = reg_ptr + 1'b1;
                ack    = 1'b1;
              end
              st_d = ST_WACK;
              oe_d = ack;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = 3'd0;
            if (rw_q) begin
              st_d  = ST_TX;
              sr_d  = rdata;
              oe_d  = ~rdata[7];
              ptr_d = reg_ptr + 1'b1;
            end else begin
              st_d = ST_RX;
              oe_d = 1'b0;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            st_d = ST_RX; oe_d = 1'b0; cnt_d = 3'd0;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              oe_d = 1'b0;
              st_d = ST_RACK;
            end else begin
              sr_d  = {sr_q[6:0], 1'b0};
              oe_d  = ~sr_q[6];
              cnt_d = cnt_q + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            cnt_d = 3'd0;
            if (mack_q) begin
              st_d  = ST_TX;
              sr_d  = rdata;
              oe_d  = ~rdata[7];
              ptr_d = reg_ptr + 1'b1;
            end else begin
              st_d = ST_IDLE;
              oe_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= 3'd0; sr_q <= 8'h00; full_q <= 1'b0;
      rw_q <= 1'b0; gc_q <= 1'b0; idx_q <= 1'b0; cmd_q <= 1'b0;
      mack_q <= 1'b0; sda_oe <= 1'b0; reg_ptr <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sr_q <= sr_d; full_q <= full_d;
      rw_q <= rw_d; gc_q <= gc_d; idx_q <= idx_d; cmd_q <= cmd_d;
      mack_q <= mack_d; sda_oe <= oe_d; reg_ptr <= ptr_d;
    end
  end

  always_comb begin
    reg_wdata = sr_q;
    pend_addr = sr_q[6:0];
  end
endmodule

// File: rtl/i2c_readdr_target.sv
module i2c_readdr_target #(
  parameter int         NREG      = 8,
  parameter int         BT_W      = 2,
  parameter logic [6:0] BASE_ADDR = 7'h20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  input  logic [BT_W-1:0] board_type,
  input  logic            nv_valid,
  input  logic [6:0]      nv_addr,
  output logic            nv_wr,
  output logic [6:0]      nv_wdata
);
  localparam int IW = $clog2(NREG);

  logic          rst_q1, rst_i;
  logic          sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [6:0]    active_addr, pend_addr;
  logic          addr_ready, pend_set, reg_we;
  logic [IW-1:0] reg_ptr;
  logic [7:0]    reg_wdata, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_i  <= rst_q1;
    end
  end

  i2ct_bus_sync u_sync (
    .clk(clk), .rst_n(rst_i), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2ct_addr_ctl #(.BT_W(BT_W), .BASE_ADDR(BASE_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_i), .board_type(board_type),
    .nv_valid(nv_valid), .nv_addr(nv_addr),
    .pend_set(pend_set), .pend_addr(pend_addr), .apply(stop_evt),
    .active_addr(active_addr), .addr_ready(addr_ready),
    .nv_wr(nv_wr), .nv_wdata(nv_wdata)
  );

  i2ct_regfile #(.NREG(NREG), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_i), .we(reg_we), .waddr(reg_ptr),
    .wdata(reg_wdata), .raddr(reg_ptr), .rdata(rdata)
  );

  i2ct_engine #(.IW(IW)) u_eng (
    .clk(clk), .rst_n(rst_i), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .active_addr(active_addr), .addr_ready(addr_ready), .rdata(rdata),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_ptr(reg_ptr),
    .reg_wdata(reg_wdata), .pend_set(pend_set), .pend_addr(pend_addr)
  );
endmodule

// File: rtl/i2c_readdr_target_chk.sv
module i2c_readdr_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       nv_wr,
  input logic [6:0] nv_wdata,
  input logic       stop_evt
);
  // R7
  nv_wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |=> !nv_wr);

  // R6
  nv_wdata_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_wr |-> (nv_wdata >= 7'h08 && nv_wdata <= 7'h77));

  // R9
  sda_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  // R4
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);
endmodule

bind i2c_readdr_target i2c_readdr_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .nv_wr(nv_wr), .nv_wdata(nv_wdata), .stop_evt(stop_evt)
);

// File: tb/i2c_readdr_target_test.sv
module i2c_readdr_target_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_low = 1'b0, mdrive = 1'b0;
  logic [1:0] board_type = 2'd0;
  logic       nv_valid = 1'b0;
  logic [6:0] nv_addr = 7'h00;
  logic       sda_oe, nv_wr;
  logic [6:0] nv_wdata;
  logic       sda_line;
  int n_tests = 0, n_fail = 0, nv_cnt = 0, viol = 0;
  logic [6:0] nv_last = 7'h00;
  logic [7:0] model [8];

  always #2 clk = ~clk;
  assign sda_line = ~(m_low | sda_oe);

  i2c_readdr_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .board_type(board_type), .nv_valid(nv_valid),
    .nv_addr(nv_addr), .nv_wr(nv_wr), .nv_wdata(nv_wdata)
  );

  always @(posedge clk) begin
    if (nv_wr) begin nv_cnt <= nv_cnt + 1; nv_last <= nv_wdata; end
    if (mdrive && sda_oe) viol <= viol + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] bt, input logic nvv, input logic [6:0] nva);
    rst_n = 1'b0; board_type = bt; nv_valid = nvv; nv_addr = nva;
    m_scl = 1'b1; m_low = 1'b0;
    tick(4); rst_n = 1'b1; tick(8);
  endtask

  task automatic wbit(input logic b);
    m_scl = 1'b0; tick(2); m_low = ~b; tick(2); mdrive = 1'b1; tick(4);
    m_scl = 1'b1; tick(8); mdrive = 1'b0; m_scl = 1'b0;
  endtask

  task automatic rbit(output logic b);
    m_scl = 1'b0; tick(2); m_low = 1'b0; tick(6);
    m_scl = 1'b1; tick(4); b = sda_line; tick(4); m_scl = 1'b0;
  endtask

  task automatic start_c();
    tick(4); m_low = 1'b0; tick(4); m_scl = 1'b1; tick(8);
    m_low = 1'b1; tick(8); m_scl = 1'b0;
  endtask

  task automatic stop_c();
    m_scl = 1'b0; tick(4); m_low = 1'b1; tick(4); m_scl = 1'b1; tick(8);
    m_low = 1'b0; tick(8);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic bt;
    for (int k = 7; k >= 0; k--) wbit(b[k]);
    rbit(bt);
    ack = ~bt;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic bb;
    for (int k = 7; k >= 0; k--) begin rbit(bb); d[k] = bb; end
    wbit(~ack);
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 29 + 11) & 255);
  endfunction

  task automatic probe(input logic [6:0] a, input logic rw, output logic ack);
    logic [7:0] d;
    start_c();
    wbyte({a, rw}, ack);
    if (rw && ack) rbyte(d, 1'b0);
    stop_c();
  endtask

  task automatic wr_seq(input logic [6:0] a, input int idx, input int n, input int seed, input string tag);
    logic ack;
    start_c();
    wbyte({a, 1'b0}, ack); check(ack, tag, ack, 1);
    wbyte(8'(idx), ack);   check(ack, tag, ack, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(pat(seed, k), ack); check(ack, tag, ack, 1);
      model[(idx + k) % 8] = pat(seed, k);
    end
    stop_c();
  endtask

  task automatic rd_seq(input logic [6:0] a, input int idx, input int n, input string tag);
    logic ack, bb;
    logic [7:0] d;
    start_c();
    wbyte({a, 1'b0}, ack); check(ack, tag, ack, 1);
    wbyte(8'(idx), ack);
    start_c();
    wbyte({a, 1'b1}, ack); check(ack, tag, ack, 1);
    for (int k = 0; k < n; k++) begin
      rbyte(d, k < n - 1);
      check(d == model[(idx + k) % 8], tag, d, model[(idx + k) % 8]);
    end
    tick(6);
    check(sda_oe == 1'b0, "R4 release after NACK", sda_oe, 0);
    rbit(bb);
    check(bb == 1'b1, "R4 no drive after NACK", bb, 1);
    stop_c();
  endtask

  task automatic cmd(input logic [6:0] a, input logic [7:0] op, input logic keep_open, output logic op_ack);
    logic ack;
    start_c();
    wbyte({a, 1'b0}, ack);
    wbyte(8'h7E, ack);
    check(ack, "R5 command index ACK", ack, 1);
    wbyte(op, op_ack);
    if (!keep_open) stop_c();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    int base_cnt;
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    do_reset(2'd0, 1'b0, 7'h00);
    check(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);
    check(nv_wr == 1'b0, "R7 reset nv_wr", nv_wr, 0);

    // R1 full address sweep, board type 0
    for (int a = 0; a < 128; a++) begin
      probe(7'(a), 1'b0, ack);
      check(ack == ((a == 'h20) || (a == 0)), "R1 sweep ACK", ack, (a == 'h20) || (a == 0));
    end
    probe(7'h00, 1'b1, ack);
    check(!ack, "R8 general-call read NACK", ack, 0);

    // R3 reset contents, then writes from every start index
    rd_seq(7'h20, 0, 9, "R3 reset contents");
    for (int s = 0; s < 8; s++) wr_seq(7'h20, s, 3, s, "R3 write");
    rd_seq(7'h20, 0, 9, "R3 readback wrap");
    rd_seq(7'h20, 5, 6, "R4 sequential read");
    wr_seq(7'h20, 8'h0B, 1, 20, "R3 index low bits");
    rd_seq(7'h20, 3, 1, "R3 index low bits read");

    // R8 general call
    wr_seq(7'h00, 2, 2, 40, "R8 general-call write");
    rd_seq(7'h20, 2, 2, "R8 general-call readback");
    base_cnt = nv_cnt;
    cmd(7'h00, 8'h30, 1'b0, ack);
    check(ack, "R8 general-call command ACK", ack, 1);
    tick(10);
    check(nv_cnt == base_cnt, "R8 no strobe", nv_cnt - base_cnt, 0);
    probe(7'h30, 1'b0, ack); check(!ack, "R8 address unchanged", ack, 0);
    probe(7'h20, 1'b0, ack); check(ack, "R8 address kept", ack, 1);

    // R6 out-of-range operands
    foreach (model[i]) ;
    for (int j = 0; j < 4; j++) begin
      logic [7:0] op;
      op = (j == 0) ? 8'h00 : (j == 1) ? 8'h07 : (j == 2) ? 8'h78 : 8'h7F;
      cmd(7'h20, op, 1'b0, ack);
      check(!ack, "R6 operand NACK", ack, 0);
    end
    tick(10);
    check(nv_cnt == base_cnt, "R6 no strobe", nv_cnt - base_cnt, 0);
    probe(7'h20, 1'b0, ack); check(ack, "R6 address kept", ack, 1);
    check(viol == 0, "R9 quiet during controller bits", viol, 0);

    // R5 / R7 boundary operands
    cmd(7'h20, 8'h08, 1'b0, ack);
    check(ack, "R5 operand 0x08 ACK", ack, 1);
    tick(10);
    check(nv_cnt == base_cnt + 1, "R7 one strobe", nv_cnt - base_cnt, 1);
    check(nv_last == 7'h08, "R7 strobe data", nv_last, 8'h08);
    probe(7'h08, 1'b0, ack); check(ack, "R5 new address ACK", ack, 1);
    probe(7'h20, 1'b0, ack); check(!ack, "R5 old address NACK", ack, 0);
    cmd(7'h08, 8'h77, 1'b0, ack);
    check(ack, "R5 operand 0x77 ACK", ack, 1);
    tick(10);
    check(nv_cnt == base_cnt + 2, "R7 second strobe", nv_cnt - base_cnt, 2);
    check(nv_last == 7'h77, "R7 strobe data 0x77", nv_last, 8'h77);
    probe(7'h77, 1'b0, ack); check(ack, "R5 address 0x77 ACK", ack, 1);

    // R5 change only at STOP, across a repeated START
    cmd(7'h77, 8'h31, 1'b1, ack);
    check(ack, "R5 operand 0x31 ACK", ack, 1);
    start_c();
    wbyte({7'h77, 1'b0}, ack);
    check(ack, "R5 old address before STOP", ack, 1);
    start_c();
    wbyte({7'h31, 1'b0}, ack);
    check(!ack, "R5 new address before STOP", ack, 0);
    stop_c();
    tick(10);
    check(nv_cnt == base_cnt + 3, "R7 strobe at STOP", nv_cnt - base_cnt, 3);
    probe(7'h31, 1'b0, ack); check(ack, "R5 address 0x31 after STOP", ack, 1);
    probe(7'h77, 1'b0, ack); check(!ack, "R5 0x77 dropped", ack, 0);
    rd_seq(7'h31, 0, 8, "R5 registers preserved");

    // R2 stored address overrides base
    do_reset(2'd0, 1'b1, 7'h42);
    probe(7'h42, 1'b0, ack); check(ack, "R2 stored address ACK", ack, 1);
    probe(7'h20, 1'b0, ack); check(!ack, "R2 base address NACK", ack, 0);

    // R1 other board types
    for (int b = 1; b < 4; b++) begin
      do_reset(2'(b), 1'b0, 7'h42);
      probe(7'(32 + b), 1'b0, ack); check(ack, "R1 board base ACK", ack, 1);
      probe(7'(31 + b), 1'b0, ack); check(!ack, "R1 below base NACK", ack, 0);
      probe(7'(33 + b), 1'b0, ack); check(!ack, "R1 above base NACK", ack, 0);
    end
    check(viol == 0, "R9 final quiet check", viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule